// File: doc/BRIEF.md
# Receive-Retriggered Counter Time-out

This block is a shared 16-bit down-counter that flags the end of a quiet period on a serial receive path. One or both receive channels can put it into time-out mode with a command code. Once in that mode, the counter is restarted by data, not by software. Each character that a channel moves into its receive FIFO reloads the counter from a preload value, which is assembled from an upper and a lower byte. When the count runs out before the next character arrives, a counter-ready status bit is set. A maskable interrupt follows from that bit. Software uses the interrupt to collect the last few characters of a message that never filled the FIFO far enough to raise a level interrupt.

The counter advances only on a C/T clock-enable pulse. A received character stops the count for one such pulse, reloads it and lets it run again from the following pulse. When both channels are in time-out mode, a character on either channel restarts the shared count. In that case expiry means both lines have been quiet for the whole interval. When no channel is in time-out mode, the counter acts as a plain counter that software starts and stops by command.

Top module: `rx_timeout_ctr`

## Requirements
- R1: After reset, time-out mode is off on every channel, counter-ready is 0, and the counter is stopped, so C/T ticks alone never set counter-ready.
- R2: A command write with code 4'hA (4-bit field `cmd_i[4*c+3:4*c]` for channel c, qualified by `cmd_we_i[c]`) enables time-out mode for channel c. It clears counter-ready on the next cycle and holds the counter stopped until a character is received.
- R3: Command code 4'hC disables time-out mode for that channel. Afterwards, character strobes on a disabled channel have no effect.
- R4: A character strobe on an enabled channel causes a reload from the preload value N at the next C/T tick, or at the tick of the same cycle if one coincides. Each later tick decrements the count. Counter-ready is set on the tick that reaches zero, which is N ticks after the reload tick. A preload of 0 behaves as 1.
- R5: Once set, counter-ready stays set and the counter stays at zero through further ticks until a clearing event occurs.
- R6: A character strobe on an enabled channel clears counter-ready, visible on the following cycle, and restarts the count even in mid-count.
- R7: `irq_o` is 1 exactly when counter-ready is 1 and `irq_mask_i` is 1.
- R8: With both channels enabled, a character on either channel restarts the one shared count, so expiry needs both channels quiet for the full period.
- R9: While any channel is in time-out mode, the start code 4'h8 and the stop code 4'h9 are ignored. They neither start, stop nor clear the counter or counter-ready.
- R10: With no channel in time-out mode, start (4'h8) clears counter-ready and reloads at the next tick, then counts as in R4. Stop (4'h9) halts the counter and clears counter-ready.
- R11: The preload value is `{preload_hi_i, preload_lo_i}`, with the upper byte in the high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ct_tick_i | input | 1 | C/T clock enable, one pulse per count step |
| preload_hi_i | input | 8 | Upper preload byte |
| preload_lo_i | input | 8 | Lower preload byte |
| char_load_i | input | 2 | Per channel: a character was moved into its receive FIFO |
| cmd_we_i | input | 2 | Per channel command write strobe |
| cmd_i | input | 8 | Per channel 4-bit command code, channel c in bits 4c+3:4c |
| irq_mask_i | input | 1 | Interrupt mask for counter-ready |
| ctr_ready_o | output | 1 | Counter-ready status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: two channels and 8-bit preload bytes, which give a 16-bit count. At this size the bench can sweep every preload from 0 to 40 and still measure the exact tick distance to expiry. It also covers the coincident-tick case, and values that separate the two preload bytes, such as 258 and 513. The two-channel build lets the bench exercise the shared retrigger and the mixing of armed and disarmed channels, including the rule that software start and stop are ignored while either channel holds the counter.

// File: rtl/rx_to_pkg.sv
package rx_to_pkg;
  localparam int CMD_W = 4;
  typedef logic [CMD_W-1:0] cmd_t;

  localparam cmd_t CMD_START  = 4'h8;
  localparam cmd_t CMD_STOP   = 4'h9;
  localparam cmd_t CMD_TO_ON  = 4'hA;
  localparam cmd_t CMD_TO_OFF = 4'hC;

  typedef struct packed {
    logic arm;
    logic start;
    logic stop;
  } chan_req_t;
endpackage

// File: rtl/rx_to_chan.sv
module rx_to_chan
  import rx_to_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  cmd_t      cmd_i,
  input  logic      char_i,
  output logic      en_o,
  output chan_req_t req_o,
  output logic      retrig_o
);
  logic en_q;
  logic disarm;

  always_comb begin
    req_o.arm   = we_i && (cmd_i == CMD_TO_ON);
    req_o.start = we_i && (cmd_i == CMD_START);
    req_o.stop  = we_i && (cmd_i == CMD_STOP);
    disarm      = we_i && (cmd_i == CMD_TO_OFF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b0;
    else if (req_o.arm)   en_q <= 1'b1;
    else if (disarm)      en_q <= 1'b0;
  end

  // retrigger uses the mode held before this cycle's command
  assign retrig_o = char_i && en_q;
  assign en_o     = en_q;
endmodule

// File: rtl/rx_to_downcnt.sv
module rx_to_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             trig_i,
  input  logic             halt_i,
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    pend_d = pend_q;
    rdy_d  = rdy_q;
    if (tick_i && run_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = '0;
        run_d = 1'b0;
        rdy_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (halt_i) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
      rdy_d  = 1'b0;
    end
    if (trig_i) begin
      rdy_d = 1'b0;
      if (tick_i) begin
        cnt_d  = preload_i;
        run_d  = 1'b1;
        pend_d = 1'b0;
      end else begin
        run_d  = 1'b0;
        pend_d = 1'b1;
      end
    end else if (pend_q && pend_d && tick_i) begin
      // stopped for this tick: reload only, count from the next one
      cnt_d  = preload_i;
      run_d  = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/rx_timeout_ctr.sv
module rx_timeout_ctr
  import rx_to_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int CMDV_W = NCH * CMD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ct_tick_i,
  input  logic [BYTE_W-1:0] preload_hi_i,
  input  logic [BYTE_W-1:0] preload_lo_i,
  input  logic [NCH-1:0]    char_load_i,
  input  logic [NCH-1:0]    cmd_we_i,
  input  logic [CMDV_W-1:0] cmd_i,
  input  logic              irq_mask_i,
  output logic              ctr_ready_o,
  output logic              irq_o
);
  logic [NCH-1:0] to_en_q;
  logic [NCH-1:0] arm_v, start_v, stop_v, retrig_v;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_req_t req;
    rx_to_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cmd_we_i[c]),
      .cmd_i    (cmd_i[c*CMD_W +: CMD_W]),
      .char_i   (char_load_i[c]),
      .en_o     (to_en_q[c]),
      .req_o    (req),
      .retrig_o (retrig_v[c])
    );
    assign arm_v[c]   = req.arm;
    assign start_v[c] = req.start;
    assign stop_v[c]  = req.stop;
  end

  logic mode_on, sw_start, sw_stop, trig, halt;

  assign mode_on  = |to_en_q;
  assign sw_start = |start_v && !mode_on;
  assign sw_stop  = |stop_v && !mode_on;
  assign trig     = |retrig_v || sw_start;
  assign halt     = |arm_v || sw_stop;

  rx_to_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (ct_tick_i),
    .preload_i ({preload_hi_i, preload_lo_i}),
    .trig_i    (trig),
    .halt_i    (halt),
    .ready_o   (ctr_ready_o)
  );

  assign irq_o = ctr_ready_o && irq_mask_i;
endmodule

// File: rtl/rx_timeout_ctr_chk.sv
module rx_timeout_ctr_chk
  import rx_to_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ct_tick_i,
  input logic [NCH-1:0]     char_load_i,
  input logic [NCH-1:0]     cmd_we_i,
  input logic [NCH*CMD_W-1:0] cmd_i,
  input logic               irq_mask_i,
  input logic               ctr_ready_o,
  input logic               irq_o,
  input logic [NCH-1:0]     to_en_q
);
  logic arm_any, sw_any, retrig_any, clr_any;

  always_comb begin
    arm_any = 1'b0;
    sw_any  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (cmd_we_i[c] && cmd_i[c*CMD_W +: CMD_W] == CMD_TO_ON) arm_any = 1'b1;
      if (cmd_we_i[c] && (cmd_i[c*CMD_W +: CMD_W] == CMD_START ||
                          cmd_i[c*CMD_W +: CMD_W] == CMD_STOP)) sw_any = 1'b1;
    end
    retrig_any = |(char_load_i & to_en_q);
    clr_any    = arm_any || retrig_any || (sw_any && (to_en_q == '0));
  end

  a_r7_irq_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctr_ready_o);

  a_r7_mask_blocks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_mask_i |-> !irq_o);

  a_r6_char_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrig_any |=> !ctr_ready_o);

  a_r2_arm_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_any |=> !ctr_ready_o);

  a_r4_ready_rises_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctr_ready_o) |-> $past(ct_tick_i));

  a_r5_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_ready_o && !clr_any) |=> ctr_ready_o);
endmodule

bind rx_timeout_ctr rx_timeout_ctr_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ct_tick_i   (ct_tick_i),
  .char_load_i (char_load_i),
  .cmd_we_i    (cmd_we_i),
  .cmd_i       (cmd_i),
  .irq_mask_i  (irq_mask_i),
  .ctr_ready_o (ctr_ready_o),
  .irq_o       (irq_o),
  .to_en_q     (to_en_q)
);

// File: tb/rx_timeout_ctr_tb_top.sv
`timescale 1ns/1ps
module rx_timeout_ctr_tb_top;
  localparam int NCH = 2;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic [BYTE_W-1:0] pre_hi = '0, pre_lo = '0;
  logic [NCH-1:0] chr = '0, we = '0;
  logic [NCH*4-1:0] cmd = '0;
  logic mask = 1'b1;
  logic rdy, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_timeout_ctr #(.NCH(NCH), .BYTE_W(BYTE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ct_tick_i(tick),
    .preload_hi_i(pre_hi), .preload_lo_i(pre_lo),
    .char_load_i(chr), .cmd_we_i(we), .cmd_i(cmd),
    .irq_mask_i(mask), .ctr_ready_o(rdy), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic n_ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic pulse_char(input int ch, input bit with_tick);
    @(negedge clk) begin chr[ch] = 1'b1; tick = with_tick; end
    @(negedge clk) begin chr = '0; tick = 1'b0; end
  endtask

  task automatic send_cmd(input int ch, input logic [3:0] code);
    @(negedge clk) begin we[ch] = 1'b1; cmd[ch*4 +: 4] = code; end
    @(negedge clk) begin we = '0; cmd = '0; end
  endtask

  task automatic set_pre(input int v);
    pre_hi = BYTE_W'(v >> BYTE_W);
    pre_lo = BYTE_W'(v);
  endtask

  task automatic ticks_to_ready(input int lim, output int n);
    n = 0;
    while (!rdy && n < lim) begin
      do_tick();
      n++;
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int sweep [5] = '{255, 256, 258, 513, 1000};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ready after reset", rdy, 0);
    check("R1 irq after reset", irq, 0);
    set_pre(2);
    n_ticks(20);
    check("R1 stopped counter", rdy, 0);

    // R3: chars ignored while mode off
    pulse_char(0, 1'b0);
    pulse_char(1, 1'b0);
    n_ticks(30);
    check("R3 char ignored when mode off", rdy, 0);

    // R2: arm channel 0 then R4/R11 sweep
    send_cmd(0, 4'hA);
    n_ticks(10);
    check("R2 armed but held stopped", rdy, 0);
    for (int v = 0; v <= 40; v++) begin
      set_pre(v);
      pulse_char(0, 1'b0);
      check("R6 char clears ready", rdy, 0);
      ticks_to_ready(eff(v) + 5, n);
      check("R4 ticks to expiry", n, eff(v) + 1);
      check("R7 irq with mask set", irq, 1);
    end
    foreach (sweep[k]) begin
      set_pre(sweep[k]);
      pulse_char(0, 1'b0);
      ticks_to_ready(sweep[k] + 5, n);
      check("R11 preload byte order", n, sweep[k] + 1);
    end

    // R5: stays set
    n_ticks(25);
    check("R5 ready holds", rdy, 1);

    // R4: coincident tick
    for (int v = 0; v <= 6; v++) begin
      set_pre(v);
      pulse_char(0, 1'b1);
      ticks_to_ready(eff(v) + 5, n);
      check("R4 coincident tick expiry", n, eff(v));
    end

    // R7: mask off
    mask = 1'b0;
    @(negedge clk);
    check("R7 ready while masked", rdy, 1);
    check("R7 irq masked", irq, 0);
    mask = 1'b1;

    // R9: start/stop ignored in mode, ready untouched
    send_cmd(1, 4'h8);
    check("R9 start leaves ready", rdy, 1);
    send_cmd(1, 4'h9);
    check("R9 stop leaves ready", rdy, 1);

    // R2: arm clears and holds
    send_cmd(0, 4'hA);
    check("R2 arm clears ready", rdy, 0);
    set_pre(3);
    n_ticks(40);
    check("R2 held after arm", rdy, 0);
    send_cmd(0, 4'h8);
    n_ticks(40);
    check("R9 start ignored in mode", rdy, 0);

    // R6: mid-count retrigger
    set_pre(10);
    pulse_char(0, 1'b0);
    n_ticks(6);
    pulse_char(0, 1'b0);
    ticks_to_ready(30, n);
    check("R6 mid-count restart", n, 11);

    // R9: stop mid-count ignored
    pulse_char(0, 1'b0);
    n_ticks(3);
    send_cmd(0, 4'h9);
    ticks_to_ready(30, n);
    check("R9 stop ignored mid-count", n, 8);

    // R8: shared counter
    send_cmd(1, 4'hA);
    pulse_char(0, 1'b0);
    n_ticks(6);
    pulse_char(1, 1'b0);
    ticks_to_ready(30, n);
    check("R8 either channel restarts", n, 11);
    pulse_char(1, 1'b0);
    ticks_to_ready(30, n);
    check("R8 channel 1 alone", n, 11);

    // R3: disarm both
    send_cmd(0, 4'hA);
    send_cmd(0, 4'hC);
    send_cmd(1, 4'hC);
    pulse_char(0, 1'b0);
    pulse_char(1, 1'b0);
    n_ticks(40);
    check("R3 char ignored after disarm", rdy, 0);

    // R10: software mode
    set_pre(10);
    send_cmd(0, 4'h8);
    ticks_to_ready(30, n);
    check("R10 start expiry", n, 11);
    send_cmd(1, 4'h9);
    check("R10 stop clears ready", rdy, 0);
    send_cmd(1, 4'h8);
    n_ticks(4);
    send_cmd(0, 4'h9);
    n_ticks(30);
    check("R10 stop halts count", rdy, 0);
    set_pre(2);
    send_cmd(0, 4'h8);
    ticks_to_ready(10, n);
    check("R10 restart after stop", n, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule